// File: doc/BRIEF.md
# Effective Address Operand Resolver

This block turns a decoded operand descriptor into an operand value. The descriptor gives the addressing mode, the operation size (byte, word or long), a register number and, for indexed modes, an index register, a scale, a displacement and flags that suppress the base or the index. Register-direct and immediate operands are formed at once. Memory operands have their address computed first. They are then fetched one byte per handshake over a simple request/ready read port, most significant byte first.

The register file of eight data and eight address registers sits outside the block. The block reads it through three combinational read ports: data, address and index. Auto-increment and auto-decrement modes return the new address-register value on a write-back port. That port is valid only in the cycle the done strobe is high, so the caller commits the register change together with the operand. A bus error reported with a read ends the operation with a fault flag, and no register changes.

Top module: `eaop_resolver`

## Requirements
- R1: Mode 0 (data register direct) returns the selected data register, with bits above the operation size forced to zero (size 0 byte = 8 bits, 1 word = 16 bits, 2 long = 32 bits), and makes no memory request.
- R2: Mode 1 (address register direct) returns all 32 bits of the selected address register, whatever the size.
- R3: Mode 7 (immediate) returns the `imm` input truncated to the operation size, and `mem_req` stays low for the whole operation.
- R4: Mode 2 (indirect) reads memory starting at the selected address register's value and asserts no write-back.
- R5: Mode 3 (post-increment) reads at the register's current value and writes back that value plus the size in bytes (1, 2 or 4).
- R6: Mode 4 (pre-decrement) reads at the register's value minus the size in bytes and writes back that lower value.
- R7: In modes 3 and 4, a byte-sized access through address register 7 moves the register by 2 instead of 1. The read uses the adjusted address in mode 4 and the unadjusted one in mode 3.
- R8: A memory read of N bytes issues N requests at ascending addresses starting at the effective address. The first byte returned becomes the most significant byte of the N-byte value, which is zero-extended to 32 bits.
- R9: Mode 5 (indexed, address base) uses address = An + (index << scale) + disp. `x_is_a`=1 selects an address register as index, else a data register. `x_long`=0 sign-extends the low 16 index bits first. `base_off` or `index_off` makes that term zero.
- R10: Mode 6 (indexed, program-counter base) uses the same formula with `pc_val` as the base, which `base_off` also suppresses.
- R11: `done` is high for exactly one cycle per accepted `start`, and `wb_en` is only ever high together with `done`.
- R12: A read accepted with `mem_err` high ends the operation. `done` and `fault` are then high together, `wb_en` stays low, and no further byte is requested.
- R13: While `mem_req` is high and `mem_ready` is low, `mem_req` and `mem_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Accept the descriptor on the inputs below (when idle) |
| mode | input | 3 | Addressing mode 0..7 as listed in the requirements |
| size | input | 2 | Operation size: 0 byte, 1 word, 2 long |
| rn | input | 3 | Register number for direct, indirect and base use |
| x_is_a | input | 1 | Index comes from the address file |
| xn | input | 3 | Index register number |
| x_long | input | 1 | Use the full 32-bit index; else sign-extend 16 bits |
| scale | input | 2 | Index shift amount 0..3 |
| base_off | input | 1 | Suppress the base term of indexed modes |
| index_off | input | 1 | Suppress the index term of indexed modes |
| imm | input | 32 | Immediate value for mode 7 |
| disp | input | 32 | Sign-extended displacement for indexed modes |
| pc_val | input | 32 | Program-counter base for mode 6 |
| busy | output | 1 | An operation is in progress |
| rf_d_sel | output | 3 | Data register read select |
| rf_d_val | input | 32 | Data register read value |
| rf_a_sel | output | 3 | Address register read select |
| rf_a_val | input | 32 | Address register read value |
| rf_x_sel | output | 4 | Index read select, bit 3 = address file |
| rf_x_val | input | 32 | Index register read value |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_ready | input | 1 | Request accepted, read data valid |
| mem_rdata | input | 8 | Read byte |
| mem_err | input | 1 | Bus error on the accepted read |
| done | output | 1 | Operand valid, one-cycle strobe |
| value | output | 32 | Operand value |
| fault | output | 1 | Operation ended on a bus error |
| wb_en | output | 1 | Commit write-back to an address register |
| wb_areg | output | 3 | Address register to update |
| wb_val | output | 32 | New address register value |

## Verification
Each mode is first tried with directed descriptors. These cover a byte post-increment and pre-decrement through register 7 against register 3, which separates the stack-alignment step from the plain size step. They also cover a negative word index, to tell sign extension from zero extension, and suppressed base and index terms. A long read with a bus error on the third byte shows that the fault stops both the fetch and the write-back. After that, several hundred random descriptors with random register contents and a memory that answers after a random delay are run. They compare the value, the byte address sequence and the write-back against a model, which catches byte-order, scaling and off-by-one step faults.

// File: rtl/eaop_pkg.sv
package eaop_pkg;

  localparam int unsigned EA_NREG  = 8;
  localparam int unsigned RIDX_W   = $clog2(EA_NREG);
  localparam int unsigned OPD_W    = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MAXB     = OPD_W / BYTE_W;
  localparam int unsigned CNT_W    = $clog2(MAXB) + 1;
  localparam int unsigned SP_INDEX = EA_NREG - 1;

  typedef enum logic [2:0] {
    EA_DREG     = 3'd0,
    EA_AREG     = 3'd1,
    EA_IND      = 3'd2,
    EA_POSTINC  = 3'd3,
    EA_PREDEC   = 3'd4,
    EA_IDX_AREG = 3'd5,
    EA_IDX_PC   = 3'd6,
    EA_IMM      = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } op_size_e;

  typedef struct packed {
    ea_mode_e          mode;
    op_size_e          size;
    logic [RIDX_W-1:0] rn;
    logic              x_is_a;
    logic [RIDX_W-1:0] xn;
    logic              x_long;
    logic [1:0]        scale;
    logic              base_off;
    logic              index_off;
  } ea_desc_t;

  // number of bytes an operand of this size occupies in memory
  function automatic logic [CNT_W-1:0] size_bytes(input op_size_e sz);
    case (sz)
      SZ_BYTE: size_bytes = CNT_W'(1);
      SZ_WORD: size_bytes = CNT_W'(2);
      default: size_bytes = CNT_W'(MAXB);
    endcase
  endfunction

  // keep only the bits that belong to the operation size
  function automatic logic [OPD_W-1:0] fit_size(input logic [OPD_W-1:0] v,
                                                input op_size_e sz);
    case (sz)
      SZ_BYTE: fit_size = {{(OPD_W-8){1'b0}}, v[7:0]};
      SZ_WORD: fit_size = {{(OPD_W-16){1'b0}}, v[15:0]};
      default: fit_size = v;
    endcase
  endfunction

endpackage

// File: rtl/eaop_addr_gen.sv
module eaop_addr_gen
  import eaop_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  ea_desc_t       desc,
  input  logic [AW-1:0]  an_val,
  input  logic [AW-1:0]  ix_val,
  input  logic [AW-1:0]  pc_base,
  input  logic [AW-1:0]  disp,
  output logic [AW-1:0]  ea,
  output logic [AW-1:0]  an_next,
  output logic           is_mem
);

  logic [CNT_W-1:0] step;
  logic [AW-1:0]    step_w;
  logic [AW-1:0]    ix_ext;
  logic [AW-1:0]    ix_term;
  logic [AW-1:0]    base_term;
  logic [AW-1:0]    an_dec;
  logic             sp_byte;

  // byte steps on the stack register keep it word aligned
  always_comb begin
    sp_byte = (desc.size == SZ_BYTE) && (desc.rn == RIDX_W'(SP_INDEX));
    step    = sp_byte ? CNT_W'(2) : size_bytes(desc.size);
    step_w  = {{(AW-CNT_W){1'b0}}, step};
    an_dec  = an_val - step_w;
  end

  always_comb begin
    if (desc.x_long) ix_ext = ix_val;
    else             ix_ext = {{(AW-16){ix_val[15]}}, ix_val[15:0]};
    ix_term = desc.index_off ? '0 : (ix_ext << desc.scale);
    if (desc.base_off)                  base_term = '0;
    else if (desc.mode == EA_IDX_PC)    base_term = pc_base;
    else                                base_term = an_val;
  end

  always_comb begin
    is_mem  = 1'b1;
    an_next = an_val;
    ea      = an_val;
    case (desc.mode)
      EA_DREG, EA_AREG, EA_IMM: is_mem = 1'b0;
      EA_IND:      ea = an_val;
      EA_POSTINC: begin
        ea      = an_val;
        an_next = an_val + step_w;
      end
      EA_PREDEC: begin
        ea      = an_dec;
        an_next = an_dec;
      end
      default:     ea = base_term + ix_term + disp;
    endcase
  end

endmodule

// File: rtl/eaop_direct_path.sv
module eaop_direct_path
  import eaop_pkg::*;
(
  input  ea_desc_t          desc,
  input  logic [OPD_W-1:0]  d_val,
  input  logic [OPD_W-1:0]  a_val,
  input  logic [OPD_W-1:0]  imm_val,
  output logic [OPD_W-1:0]  result
);

  always_comb begin
    case (desc.mode)
      EA_DREG: result = fit_size(d_val, desc.size);
      EA_AREG: result = a_val;
      EA_IMM:  result = fit_size(imm_val, desc.size);
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/eaop_byte_fetch.sv
module eaop_byte_fetch
  import eaop_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AW-1:0]     go_addr,
  input  logic [CNT_W-1:0]  go_len,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ready,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              fin,
  output logic              fin_err,
  output logic [OPD_W-1:0]  fin_data
);

  logic              run_q, run_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [OPD_W-1:0]  acc_q, acc_d;
  logic              accept;
  logic              upd;

  always_comb begin
    accept   = run_q & mem_ready;
    fin_data = {acc_q[OPD_W-BYTE_W-1:0], mem_rdata};
    fin      = accept & (mem_err | (left_q == CNT_W'(1)));
    fin_err  = accept & mem_err;
    upd      = go | accept;
    if (go) begin
      run_d  = 1'b1;
      addr_d = go_addr;
      left_d = go_len;
      acc_d  = '0;
    end else begin
      run_d  = run_q & ~fin;
      addr_d = addr_q + AW'(1);
      left_d = left_q - CNT_W'(1);
      acc_d  = fin_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      acc_q  <= '0;
    end else if (upd) begin
      run_q  <= run_d;
      addr_q <= addr_d;
      left_q <= left_d;
      acc_q  <= acc_d;
    end
  end

  assign mem_req  = run_q;
  assign mem_addr = addr_q;

endmodule

// File: rtl/eaop_resolver.sv
module eaop_resolver
  import eaop_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          mode,
  input  logic [1:0]          size,
  input  logic [RIDX_W-1:0]   rn,
  input  logic                x_is_a,
  input  logic [RIDX_W-1:0]   xn,
  input  logic                x_long,
  input  logic [1:0]          scale,
  input  logic                base_off,
  input  logic                index_off,
  input  logic [OPD_W-1:0]    imm,
  input  logic [AW-1:0]       disp,
  input  logic [AW-1:0]       pc_val,
  output logic                busy,
  output logic [RIDX_W-1:0]   rf_d_sel,
  input  logic [OPD_W-1:0]    rf_d_val,
  output logic [RIDX_W-1:0]   rf_a_sel,
  input  logic [AW-1:0]       rf_a_val,
  output logic [RIDX_W:0]     rf_x_sel,
  input  logic [OPD_W-1:0]    rf_x_val,
  output logic                mem_req,
  output logic [AW-1:0]       mem_addr,
  input  logic                mem_ready,
  input  logic [BYTE_W-1:0]   mem_rdata,
  input  logic                mem_err,
  output logic                done,
  output logic [OPD_W-1:0]    value,
  output logic                fault,
  output logic                wb_en,
  output logic [RIDX_W-1:0]   wb_areg,
  output logic [AW-1:0]       wb_val
);

  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_FETCH, ST_DONE} ctl_state_e;

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctl_state_e        state_q, state_d;
  ea_desc_t          desc_q, desc_d;
  logic [OPD_W-1:0]  imm_q;
  logic [AW-1:0]     disp_q, pc_q;
  logic [OPD_W-1:0]  val_q, val_d;
  logic              fault_q, fault_d;
  logic              wbp_q, wbp_d;
  logic [AW-1:0]     wbv_q;
  logic              ld_desc, ld_calc, ld_res, fetch_go;

  logic [AW-1:0]     ea, an_next;
  logic              is_mem;
  logic [OPD_W-1:0]  direct_val;
  logic              fetch_fin, fetch_err;
  logic [OPD_W-1:0]  fetch_data;

  always_comb begin
    desc_d.mode      = ea_mode_e'(mode);
    desc_d.size      = op_size_e'(size);
    desc_d.rn        = rn;
    desc_d.x_is_a    = x_is_a;
    desc_d.xn        = xn;
    desc_d.x_long    = x_long;
    desc_d.scale     = scale;
    desc_d.base_off  = base_off;
    desc_d.index_off = index_off;
  end

  assign rf_d_sel = desc_q.rn;
  assign rf_a_sel = desc_q.rn;
  assign rf_x_sel = {desc_q.x_is_a, desc_q.xn};

  eaop_addr_gen #(.AW(AW)) u_addr (
    .desc    (desc_q),
    .an_val  (rf_a_val),
    .ix_val  (rf_x_val),
    .pc_base (pc_q),
    .disp    (disp_q),
    .ea      (ea),
    .an_next (an_next),
    .is_mem  (is_mem)
  );

  eaop_direct_path u_direct (
    .desc    (desc_q),
    .d_val   (rf_d_val),
    .a_val   (rf_a_val),
    .imm_val (imm_q),
    .result  (direct_val)
  );

  eaop_byte_fetch #(.AW(AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .go        (fetch_go),
    .go_addr   (ea),
    .go_len    (size_bytes(desc_q.size)),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_err   (mem_err),
    .fin       (fetch_fin),
    .fin_err   (fetch_err),
    .fin_data  (fetch_data)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    ld_desc  = 1'b0;
    ld_calc  = 1'b0;
    ld_res   = 1'b0;
    fetch_go = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        ld_desc = 1'b1;
        state_d = ST_CALC;
      end
      ST_CALC: begin
        ld_calc = 1'b1;
        if (is_mem) begin
          fetch_go = 1'b1;
          state_d  = ST_FETCH;
        end else begin
          ld_res  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_FETCH: if (fetch_fin) begin
        ld_res  = 1'b1;
        state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
    val_d   = (state_q == ST_FETCH) ? fetch_data : direct_val;
    fault_d = (state_q == ST_FETCH) & fetch_err;
    wbp_d   = (desc_q.mode == EA_POSTINC) || (desc_q.mode == EA_PREDEC);
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      desc_q <= '0;
      imm_q  <= '0;
      disp_q <= '0;
      pc_q   <= '0;
    end else if (ld_desc) begin
      desc_q <= desc_d;
      imm_q  <= imm;
      disp_q <= disp;
      pc_q   <= pc_val;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wbp_q <= 1'b0;
      wbv_q <= '0;
    end else if (ld_calc) begin
      wbp_q <= wbp_d;
      wbv_q <= an_next;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      val_q   <= '0;
      fault_q <= 1'b0;
    end else if (ld_res) begin
      val_q   <= val_d;
      fault_q <= fault_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_DONE);
  assign value   = val_q;
  assign fault   = done & fault_q;
  assign wb_en   = done & wbp_q & ~fault_q;
  assign wb_areg = desc_q.rn;
  assign wb_val  = wbv_q;

endmodule

// File: rtl/eaop_resolver_chk.sv
module eaop_resolver_chk
  import eaop_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              mem_req,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_ready,
  input logic              mem_err,
  input logic              done,
  input logic              fault,
  input logic              wb_en
);

  // R11: done is a single-cycle strobe
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: write-back only together with done
  assert_wb_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  // R12: a faulted operation never writes back
  assert_fault_no_wb_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && !wb_en));

  // R12: no further request after the erroring byte
  assert_err_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && mem_err) |=> !mem_req);

  // R13: a waiting request holds its address
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R3: no memory traffic while the result is presented
  assert_no_req_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // R11: done only occurs during an operation
  assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

endmodule

bind eaop_resolver eaop_resolver_chk #(.AW(AW)) u_chk (.*);

// File: tb/eaop_resolver_bench.sv
module eaop_resolver_bench;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  mode;
  logic [1:0]  size;
  logic [2:0]  rn;
  logic        x_is_a;
  logic [2:0]  xn;
  logic        x_long;
  logic [1:0]  scale;
  logic        base_off;
  logic        index_off;
  logic [31:0] imm, disp, pc_val;
  logic        busy;
  logic [2:0]  rf_d_sel, rf_a_sel;
  logic [3:0]  rf_x_sel;
  logic [31:0] rf_d_val, rf_a_val, rf_x_val;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready;
  logic [7:0]  mem_rdata;
  logic        mem_err;
  logic        done;
  logic [31:0] value;
  logic        fault;
  logic        wb_en;
  logic [2:0]  wb_areg;
  logic [31:0] wb_val;

  logic [31:0] dreg [8];
  logic [31:0] areg [8];
  logic [31:0] log_addr [8];
  int          log_n;
  int          err_at;
  int          wait_cnt;
  int          n_checks;
  int          n_errors;

  eaop_resolver u_eaop_resolver (.*);

  assign rf_d_val = dreg[rf_d_sel];
  assign rf_a_val = areg[rf_a_sel];
  assign rf_x_val = rf_x_sel[3] ? areg[rf_x_sel[2:0]] : dreg[rf_x_sel[2:0]];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ a[31:24] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] fit(input logic [31:0] v, input logic [1:0] sz);
    if (sz == 2'd0) return {24'd0, v[7:0]};
    if (sz == 2'd1) return {16'd0, v[15:0]};
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: random 0..2 cycle wait per byte
  initial begin
    mem_ready = 1'b0; mem_rdata = 8'h00; mem_err = 1'b0; wait_cnt = 0;
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      mem_err   = 1'b0;
      if (mem_req === 1'b1) begin
        if (wait_cnt == 0) begin
          mem_ready = 1'b1;
          mem_rdata = mbyte(mem_addr);
          mem_err   = (log_n == err_at);
          if (log_n < 8) log_addr[log_n] = mem_addr;
          log_n++;
          wait_cnt  = int'($urandom % 3);
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  task automatic run_op(input logic [2:0] m, input logic [1:0] sz, input logic [2:0] r,
                        input logic xa, input logic [2:0] xr, input logic xl,
                        input logic [1:0] sc, input logic bo, input logic io,
                        input logic [31:0] im, input logic [31:0] ds, input logic [31:0] pc,
                        input int ea_err);
    int nb, step, cyc, exp_reqs;
    logic [31:0] an, xv, ixr, ix, ea, ev, wbv;
    logic exp_fault, exp_wb, mem_op;
    string vreq, wreq;
    nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    step = (sz == 2'd0 && r == 3'd7) ? 2 : nb;
    an   = areg[r];
    xv   = xa ? areg[xr] : dreg[xr];
    ixr  = xl ? xv : {{16{xv[15]}}, xv[15:0]};
    ix   = io ? 32'd0 : (ixr << sc);
    mem_op = !(m == 3'd0 || m == 3'd1 || m == 3'd7);
    case (m)
      3'd0: begin ev = fit(dreg[r], sz); vreq = "R1"; end
      3'd1: begin ev = an; vreq = "R2"; end
      3'd7: begin ev = fit(im, sz); vreq = "R3"; end
      3'd2: begin ea = an; vreq = "R4"; end
      3'd3: begin ea = an; vreq = "R5"; end
      3'd4: begin ea = an - step; vreq = "R6"; end
      3'd5: begin ea = (bo ? 32'd0 : an) + ix + ds; vreq = "R9"; end
      default: begin ea = (bo ? 32'd0 : pc) + ix + ds; vreq = "R10"; end
    endcase
    if ((m == 3'd3 || m == 3'd4) && sz == 2'd0 && r == 3'd7) vreq = "R7";
    wreq = vreq;
    exp_fault = mem_op && (ea_err < nb);
    if (mem_op) begin
      ev = 32'd0;
      for (int i = 0; i < nb; i++) ev = (ev << 8) | {24'd0, mbyte(ea + i)};
    end
    exp_wb = (m == 3'd3 || m == 3'd4) && !exp_fault;
    wbv    = (m == 3'd3) ? an + step : an - step;
    exp_reqs = !mem_op ? 0 : exp_fault ? ea_err + 1 : nb;

    @(negedge clk);
    log_n = 0; err_at = ea_err;
    mode = m; size = sz; rn = r; x_is_a = xa; xn = xr; x_long = xl; scale = sc;
    base_off = bo; index_off = io; imm = im; disp = ds; pc_val = pc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (done !== 1'b1 && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    chk("R11 done seen", {31'd0, done}, 32'd1);
    if (!exp_fault) chk(vreq, value, ev);
    chk(exp_fault ? "R12 fault" : "R12 no fault", {31'd0, fault}, {31'd0, exp_fault});
    chk(exp_fault ? "R12 no write-back" : wreq, {31'd0, wb_en}, {31'd0, exp_wb});
    if (exp_wb) begin
      chk(wreq, wb_val, wbv);
      chk(wreq, {29'd0, wb_areg}, {29'd0, r});
      areg[r] = wb_val;
    end
    if (m == 3'd7) chk("R3 no request", log_n, 0);
    else chk("R8 request count", log_n, exp_reqs);
    if (mem_op && log_n == exp_reqs)
      for (int i = 0; i < exp_reqs; i++) chk("R8 address order", log_addr[i], ea + i);
    @(negedge clk);
    chk("R11 single cycle done", {31'd0, done}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    n_checks = 0; n_errors = 0; log_n = 0; err_at = 99;
    start = 0; mode = 0; size = 0; rn = 0; x_is_a = 0; xn = 0; x_long = 0; scale = 0;
    base_off = 0; index_off = 0; imm = 0; disp = 0; pc_val = 0;
    for (int i = 0; i < 8; i++) begin
      dreg[i] = $urandom;
      areg[i] = $urandom;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state, R11
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset wb_en", {31'd0, wb_en}, 32'd0);
    chk("R13 reset mem_req", {31'd0, mem_req}, 32'd0);

    // directed corner cases
    dreg[2] = 32'hCAFE_8123;
    run_op(3'd0, 2'd0, 3'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 99);  // R1 byte
    run_op(3'd0, 2'd1, 3'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 99);  // R1 word
    run_op(3'd1, 2'd0, 3'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 99);  // R2
    run_op(3'd7, 2'd1, 3'd0, 0, 0, 0, 0, 0, 0, 32'h1234_5678, 0, 0, 99); // R3
    areg[7] = 32'h0000_2000;
    run_op(3'd3, 2'd0, 3'd7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 99);  // R7 postinc
    run_op(3'd4, 2'd0, 3'd7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 99);  // R7 predec
    areg[3] = 32'h0000_1001;
    run_op(3'd3, 2'd0, 3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 99);  // R5 step 1
    run_op(3'd4, 2'd2, 3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 99);  // R6 long
    run_op(3'd2, 2'd2, 3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 99);  // R4, R8
    dreg[4] = 32'h0001_FFF8;  // word index -8
    run_op(3'd5, 2'd1, 3'd3, 0, 3'd4, 0, 2'd1, 0, 0, 0, 32'd16, 0, 99); // R9 sign ext
    run_op(3'd5, 2'd1, 3'd3, 0, 3'd4, 1, 2'd0, 0, 1, 0, 32'd16, 0, 99); // R9 no index
    run_op(3'd6, 2'd2, 3'd3, 1, 3'd7, 1, 2'd3, 1, 0, 0, 32'hFFFF_FFF0, 32'h400, 99); // R10 no base
    run_op(3'd6, 2'd0, 3'd3, 1, 3'd7, 0, 2'd2, 0, 0, 0, 32'd6, 32'h400, 99); // R10
    run_op(3'd3, 2'd2, 3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);   // R12 error on third byte
    run_op(3'd2, 2'd0, 3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);   // R12 error on only byte

    // random descriptors
    for (int k = 0; k < 400; k++) begin
      logic [1:0] rsz;
      rsz = 2'($urandom % 3);
      if (k % 40 == 0)
        for (int i = 0; i < 8; i++) dreg[i] = $urandom;
      run_op(3'($urandom), rsz, 3'($urandom), 1'($urandom), 3'($urandom),
             1'($urandom), 2'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0,
             $urandom, $urandom, $urandom, (($urandom % 10) == 0) ? int'($urandom % 4) : 99);
    end

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule